// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This unit forms the second operand of a 32-bit data-processing datapath and the carry that the shifter produces beside it. A register value is shifted left or right, arithmetically shifted, rotated, or rotated through carry by one place. The amount comes either from a 5-bit immediate field or from the low byte of a second register. A bypass select skips the shifter and passes a 32-bit immediate through unchanged.

The carry rules follow a processor's conventions for every corner: a zero amount, an amount of exactly the word width, and amounts beyond it. Both outputs are registered, so a result appears one clock after its inputs are presented. The arithmetic unit that consumes the operand and the flag writeback sit outside this block.

Top module: `opsh_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `operand` becomes 0 and `carry_out` becomes 0.
- R2: Both outputs are registered. Inputs present at a rising edge show up on `operand` and `carry_out` after that edge and hold until the next edge.
- R3: When `bypass_imm` is 1, `operand` equals `imm_val` and `carry_out` equals `carry_in`. Shift type and amount are then ignored.
- R4: The shift amount is `reg_amt[7:0]` when `use_reg_amt` is 1 and `imm_amt` otherwise. Bits 31:8 of `reg_amt` have no effect.
- R5: With shift type 0 (left), 1 (logical right), 2 (arithmetic right) or 3 (rotate) and an amount of 0, `operand` equals `src_val` and `carry_out` equals `carry_in`.
- R6: Type 0, amount n in 1..32: `operand` is `src_val` shifted left by n, and `carry_out` is bit 32−n of `src_val`. Above 32, both are 0.
- R7: Type 1, amount n in 1..32: `operand` is `src_val` shifted right with zero fill, and `carry_out` is bit n−1 of `src_val`. Above 32, both are 0.
- R8: Type 2, amount n in 1..31: `operand` is shifted right with sign fill, and `carry_out` is bit n−1 of `src_val`. At 32 or more, every bit of `operand` and `carry_out` equal bit 31 of `src_val`.
- R9: Type 3, nonzero amount n: `operand` is `src_val` rotated right by n mod 32, and `carry_out` equals bit 31 of that result. For example, n = 32 gives the value unchanged with carry equal to its bit 31.
- R10: Type 4 ignores the amount. `operand` is `{carry_in, src_val[31:1]}` and `carry_out` is `src_val[0]`.
- R11: Type codes 5, 6 and 7 pass `src_val` through with `carry_out` equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Value to be shifted |
| sh_kind | input | 3 | Shift type code (0..4 defined) |
| use_reg_amt | input | 1 | 1: amount from register low byte; 0: immediate amount |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 32 | Register holding the shift amount |
| carry_in | input | 1 | Current carry flag |
| bypass_imm | input | 1 | 1: pass the immediate operand |
| imm_val | input | 32 | Immediate operand |
| operand | output | 32 | Registered operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
Each result is due one rising edge after its inputs are applied, because a single register stage lies between any input and either output. The bench changes inputs on the falling edge and compares on the next falling edge. That is half a period after the capturing edge and before the next input change, so every comparison sees exactly the inputs it was computed from. The checker makes the same one-cycle link through a single `$past`.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int unsigned KIND_W = 3;
  localparam logic [KIND_W-1:0] K_SHL  = 3'd0;
  localparam logic [KIND_W-1:0] K_SHR  = 3'd1;
  localparam logic [KIND_W-1:0] K_SAR  = 3'd2;
  localparam logic [KIND_W-1:0] K_ROT  = 3'd3;
  localparam logic [KIND_W-1:0] K_RCX  = 3'd4;

  typedef struct packed {
    logic        carry;
  } opsh_flag_t;
endpackage

// File: rtl/opsh_amount_sel.sv
module opsh_amount_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  parameter int unsigned IMM_W  = 5
) (
  input  logic              use_reg_amt,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  output logic [AMT_W-1:0]  amt
);
  localparam int unsigned PAD_W = AMT_W - IMM_W;

  // Only the low byte of the register contributes; the rest is dropped here.
  logic unused_hi_bits;
  assign unused_hi_bits = ^reg_amt[DATA_W-1:AMT_W];

  always_comb begin
    if (use_reg_amt) amt = reg_amt[AMT_W-1:0];
    else             amt = {{PAD_W{1'b0}}, imm_amt};
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [KIND_W-1:0] sh_kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int unsigned WIDE_W = 2 * DATA_W;
  localparam int unsigned LOG_W  = $clog2(DATA_W);

  logic [AMT_W-1:0]         n_clamp;
  logic                     over;
  logic                     zero_amt;
  logic [WIDE_W-1:0]        left_w;
  logic [WIDE_W-1:0]        right_w;
  logic signed [WIDE_W-1:0] arith_w;
  logic [WIDE_W-1:0]        rot_w;
  logic [LOG_W-1:0]         rot_n;

  assign over     = amt > AMT_W'(DATA_W);
  assign zero_amt = (amt == '0);
  assign n_clamp  = over ? AMT_W'(DATA_W) : amt;
  assign rot_n    = amt[LOG_W-1:0];

  // Wide shifts keep the last bit shifted out at a fixed position.
  assign left_w  = {{DATA_W{1'b0}}, src_val} << n_clamp;
  assign right_w = {src_val, {DATA_W{1'b0}}} >> n_clamp;
  assign arith_w = $signed({src_val, {DATA_W{1'b0}}}) >>> n_clamp;
  assign rot_w   = {src_val, src_val} >> rot_n;

  always_comb begin
    res  = src_val;
    cout = carry_in;
    unique case (sh_kind)
      K_SHL: if (!zero_amt) begin
        res  = over ? '0 : left_w[DATA_W-1:0];
        cout = over ? 1'b0 : left_w[DATA_W];
      end
      K_SHR: if (!zero_amt) begin
        res  = over ? '0 : right_w[WIDE_W-1:DATA_W];
        cout = over ? 1'b0 : right_w[DATA_W-1];
      end
      K_SAR: if (!zero_amt) begin
        res  = arith_w[WIDE_W-1:DATA_W];
        cout = over ? src_val[DATA_W-1] : arith_w[DATA_W-1];
      end
      K_ROT: if (!zero_amt) begin
        res  = rot_w[DATA_W-1:0];
        cout = rot_w[DATA_W-1];
      end
      K_RCX: begin
        res  = {carry_in, src_val[DATA_W-1:1]};
        cout = src_val[0];
      end
      default: begin
        res  = src_val;
        cout = carry_in;
      end
    endcase
  end
endmodule

// File: rtl/opsh_top.sv
module opsh_top
  import opsh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  parameter int unsigned IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_val,
  input  logic [2:0]        sh_kind,
  input  logic              use_reg_amt,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic              carry_in,
  input  logic              bypass_imm,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out
);
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  opsh_flag_t        flag_q;

  opsh_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) i_amt (
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .amt         (amt)
  );

  opsh_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_barrel (
    .src_val  (src_val),
    .sh_kind  (sh_kind),
    .amt      (amt),
    .carry_in (carry_in),
    .res      (sh_res),
    .cout     (sh_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand      <= '0;
      flag_q.carry <= 1'b0;
    end else if (bypass_imm) begin
      operand      <= imm_val;
      flag_q.carry <= carry_in;
    end else begin
      operand      <= sh_res;
      flag_q.carry <= sh_cout;
    end
  end

  assign carry_out = flag_q.carry;
endmodule

// File: rtl/opsh_chk.sv
module opsh_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  parameter int unsigned IMM_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] src_val,
  input logic [2:0]        sh_kind,
  input logic              use_reg_amt,
  input logic [IMM_W-1:0]  imm_amt,
  input logic [DATA_W-1:0] reg_amt,
  input logic              carry_in,
  input logic              bypass_imm,
  input logic [DATA_W-1:0] imm_val,
  input logic [DATA_W-1:0] operand,
  input logic              carry_out
);
  logic armed = 1'b0;
  logic [AMT_W-1:0] eff_amt;
  assign eff_amt = use_reg_amt ? reg_amt[AMT_W-1:0] : AMT_W'(imm_amt);

  always_ff @(posedge clk) armed <= !rst;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (operand == '0 && carry_out == 1'b0));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(bypass_imm) |-> (operand == $past(imm_val) && carry_out == $past(carry_in)));

  assert_zero_amount_R5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(bypass_imm) && $past(sh_kind) <= 3'd3 && $past(eff_amt) == '0
      |-> (operand == $past(src_val) && carry_out == $past(carry_in)));

  assert_left_over_R6: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(bypass_imm) && $past(sh_kind) == 3'd0 && $past(eff_amt) > AMT_W'(DATA_W)
      |-> (operand == '0 && carry_out == 1'b0));

  assert_rot_carry_R9: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(bypass_imm) && $past(sh_kind) == 3'd3 && $past(eff_amt) != '0
      |-> carry_out == operand[DATA_W-1]);

  assert_rrx_R10: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(bypass_imm) && $past(sh_kind) == 3'd4
      |-> (operand == {$past(carry_in), $past(src_val[DATA_W-1:1])} && carry_out == $past(src_val[0])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(bypass_imm) && bypass_imm |=> operand == $past(imm_val));
endmodule

bind opsh_top opsh_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W)) i_chk (
  .clk(clk), .rst(rst), .src_val(src_val), .sh_kind(sh_kind),
  .use_reg_amt(use_reg_amt), .imm_amt(imm_amt), .reg_amt(reg_amt),
  .carry_in(carry_in), .bypass_imm(bypass_imm), .imm_val(imm_val),
  .operand(operand), .carry_out(carry_out)
);

// File: tb/test_opsh_top.sv
module test_opsh_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_val, reg_amt, imm_val;
  logic [2:0]  sh_kind;
  logic        use_reg_amt, carry_in, bypass_imm;
  logic [4:0]  imm_amt;
  logic [31:0] operand;
  logic        carry_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opsh_top i_opsh_top (
    .clk(clk), .rst(rst), .src_val(src_val), .sh_kind(sh_kind),
    .use_reg_amt(use_reg_amt), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .carry_in(carry_in), .bypass_imm(bypass_imm), .imm_val(imm_val),
    .operand(operand), .carry_out(carry_out)
  );

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Bit-level reference built from the requirements.
  task automatic ref_model(input logic [31:0] v, input logic [2:0] k, input int n,
                           input logic ci, output logic [31:0] r, output logic co);
    r = v; co = ci;
    if (k == 3'd4) begin
      r = {ci, v[31:1]}; co = v[0];
    end else if (k <= 3'd3 && n != 0) begin
      case (k)
        3'd0: begin
          for (int i = 0; i < 32; i++) r[i] = (i >= n) ? v[i-n] : 1'b0;
          co = (n <= 32) ? v[32-n] : 1'b0;
        end
        3'd1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
          co = (n <= 32) ? v[n-1] : 1'b0;
        end
        3'd2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : v[31];
          co = (n >= 32) ? v[31] : v[n-1];
        end
        default: begin
          for (int i = 0; i < 32; i++) r[i] = v[(i + n % 32) % 32];
          co = r[31];
        end
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    n_cmp++;
    if (operand !== er || carry_out !== ec) begin
      n_bad++;
      $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
               req, operand, carry_out, er, ec);
    end
  endtask

  // Apply on a falling edge; result due one rising edge later, compared on the next falling edge.
  task automatic apply_shift(input logic [31:0] v, input logic [2:0] k, input logic ureg,
                             input logic [4:0] ia, input logic [31:0] ra, input logic ci,
                             input string tag);
    logic [31:0] er; logic ec; int n;
    src_val = v; sh_kind = k; use_reg_amt = ureg; imm_amt = ia; reg_amt = ra;
    carry_in = ci; bypass_imm = 1'b0; imm_val = 32'hDEAD_BEEF;
    n = ureg ? int'(ra[7:0]) : int'(ia);
    ref_model(v, k, n, ci, er, ec);
    @(negedge clk);
    check(tag.len() != 0 ? tag : req_of(k), er, ec);
  endtask

  initial begin
    automatic logic [31:0] pats[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_1E69, 32'h0000_0000};
    automatic int amts[9] = '{0, 1, 2, 15, 31, 32, 33, 64, 255};
    rst = 1'b1; src_val = '0; sh_kind = '0; use_reg_amt = 0; imm_amt = '0;
    reg_amt = '0; carry_in = 0; bypass_imm = 0; imm_val = '0;
    @(negedge clk); @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;

    // R3: bypass ignores shift controls.
    for (int c = 0; c < 2; c++) begin
      src_val = 32'h1234_5678; sh_kind = 3'd0; use_reg_amt = 1; reg_amt = 32'd4;
      imm_val = 32'hCAFE_0000 + c; carry_in = c[0]; bypass_imm = 1;
      @(negedge clk);
      check("R3", 32'hCAFE_0000 + c, c[0]);
    end
    // R2: outputs hold between edges.
    #5 check("R2", 32'hCAFE_0001, 1'b1);

    // R6..R11 with register amounts including 0,1,31,32,33,255 (R5 at 0).
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 9; a++)
          for (int c = 0; c < 2; c++)
            apply_shift(pats[p], 3'(k), 1'b1, 5'd0, 32'(amts[a]), c[0],
                        (amts[a] == 0 && k < 4) ? "R5" : "");
    // Full immediate-amount sweep.
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 32; a++)
        for (int c = 0; c < 2; c++)
          apply_shift(32'hA5C3_1E69, 3'(k), 1'b0, 5'(a), 32'hFFFF_FFFF, c[0], "");
    // R4: upper register bits ignored; immediate ignored in register mode.
    apply_shift(32'hF000_000F, 3'd1, 1'b1, 5'd9, 32'hFFFF_FF04, 1'b0, "R4");
    apply_shift(32'hF000_000F, 3'd0, 1'b1, 5'd1, 32'h1234_0000, 1'b1, "R4");
    apply_shift(32'hF000_000F, 3'd3, 1'b0, 5'd4, 32'h0000_0008, 1'b0, "R4");
    // R1 again: reset mid-run clears outputs.
    rst = 1'b1; @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule